// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked system and an asynchronous static RAM of 131,072 bytes. It accepts one single-word request at a time on a valid/ready port and plays it out as a read or write cycle on the memory's pins. Those pins are a 17-bit address, a pair of chip selects of opposite polarity, a write strobe, an output strobe and an 8-bit bidirectional data bus. The data bus is presented here as separate out, in and drive-enable signals. Cycle lengths are parameters counted in clocks: `T_CYCLE` sets the length of every memory cycle and `T_OE` sets how many clocks the output strobe is active before read data is taken.

All memory pins come straight from registers. When idle the chip is deselected, so the memory is in standby and its data pins float. A read keeps the write strobe high and drops the output strobe only for the last `T_OE` clocks. The byte on the bus is captured at the end of the cycle and returned with a one-clock strobe. A write drops the write strobe for `T_CYCLE-1` clocks and then raises it while address, data and chip select are still held, so the memory latches on that rising edge.

The request port follows valid/ready rules. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, and it stays low for the whole cycle that follows a transfer. A requester that sees `req_ready` low must hold `req_valid` and its fields steady until a transfer edge. The read-data strobe has no back-pressure.

Top module: `sram_ctl`

## Requirements
- R1: After reset and in every clock where `req_ready` is high, the pins are in standby: `mem_sel_n`=1, `mem_sel`=0, `mem_wr_n`=1, `mem_rd_n`=1 and `mem_dq_oe`=0.
- R2: `req_ready` is high exactly when idle. After a transfer it is low for exactly `T_CYCLE` clocks and then high again, so a held request is taken only once.
- R3: `mem_sel_n` is always the inverse of `mem_sel`. The chip is selected (`mem_sel_n`=0, `mem_sel`=1) in every busy clock and in no idle clock.
- R4: During a read, `mem_wr_n` stays 1 and `mem_dq_oe` stays 0. `mem_rd_n` is 0 in exactly the last `T_OE` clocks of the cycle, and `mem_rd_n` and `mem_wr_n` are never both 0.
- R5: Read data is the byte on `mem_dq_in` at the last clock edge of the read cycle. It appears on `rsp_data` in the first idle clock, with `rsp_valid` high for that single clock only.
- R6: During a write, `mem_rd_n` stays 1 and `mem_wr_n` is 0 for the first `T_CYCLE-1` clocks. It then rises for one final clock in which chip select, address and `mem_dq_out` are unchanged, so the memory stores the write data at the write-strobe rising edge.
- R7: `mem_dq_oe` is 1 only during write cycles. It never rises unless `mem_rd_n` was already 1 in the clock before, so between a read and a following write there is at least one clock with `mem_rd_n`=1 and `mem_dq_oe`=0.
- R8: `mem_addr` holds the transferred `req_addr` unchanged through every clock of the cycle. `mem_dq_out` holds `req_wdata` through every clock of a write.
- R9: A write produces no `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-clock read-data strobe |
| rsp_data | output | 8 | Read data |
| mem_addr | output | 17 | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output strobe |
| mem_dq_out | output | 8 | Data driven to memory |
| mem_dq_in | input | 8 | Data from memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
The assertions watch, on every clock, the pin-level rules that need no memory contents. These are the standby state while idle, the paired chip selects, the strobes never being active together, the turnaround before the data driver turns on, the stable address and data inside a cycle, chip select held at the write-strobe rising edge, and a single-clock read strobe. Only the bench scenarios can show that the cycle lengths and the `T_OE` window are correct. They also show that a byte written really lands at its address and reads back. A read issued straight before a write to the same address must return the old byte, and a request held valid while the controller is busy must be taken exactly once.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_WHOLD = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 3,
  parameter int CNT_MAX = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (restart)
      count <= '0;
    else if (count != TOP)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int T_CYCLE = 4,
  parameter int T_OE    = 2,
  parameter int CNT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  count,
  output logic              restart,
  output logic              req_ready,
  output logic              read_last,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  localparam int OE_START = T_CYCLE - T_OE;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(T_CYCLE - 1);
  localparam logic [CNT_W-1:0] WE_END = CNT_W'(T_CYCLE - 2);
  localparam logic [CNT_W-1:0] OE_AT  = CNT_W'(OE_START);
  localparam logic OE_FIRST = (OE_START == 0) ? 1'b0 : 1'b1;

  ctl_state_t state;
  logic       accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign restart   = accept;
  assign read_last = (state == ST_READ) && (count == LAST_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mem_addr   <= '0;
      mem_sel_n  <= 1'b1;
      mem_sel    <= 1'b0;
      mem_wr_n   <= 1'b1;
      mem_rd_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            mem_addr  <= req_addr;
            mem_sel_n <= 1'b0;
            mem_sel   <= 1'b1;
            if (req_write) begin
              state      <= ST_WRITE;
              mem_wr_n   <= 1'b0;
              mem_rd_n   <= 1'b1;
              mem_dq_out <= req_wdata;
              mem_dq_oe  <= 1'b1;
            end else begin
              state    <= ST_READ;
              mem_wr_n <= 1'b1;
              mem_rd_n <= OE_FIRST;
            end
          end
        end
        ST_READ: begin
          if (count == LAST_C) begin
            state     <= ST_IDLE;
            mem_sel_n <= 1'b1;
            mem_sel   <= 1'b0;
            mem_rd_n  <= 1'b1;
          end else begin
            mem_rd_n <= !((count + 1'b1) >= OE_AT);
          end
        end
        ST_WRITE: begin
          if (count == WE_END) begin
            state    <= ST_WHOLD;
            mem_wr_n <= 1'b1;
          end
        end
        ST_WHOLD: begin
          state     <= ST_IDLE;
          mem_sel_n <= 1'b1;
          mem_sel   <= 1'b0;
          mem_dq_oe <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctl_capture.sv
module sram_ctl_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sample;
      if (sample)
        rsp_data <= dq_in;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int T_CYCLE = 4,
  parameter int T_OE    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int CNT_W = $clog2(T_CYCLE + 1);

  logic             restart;
  logic             read_last;
  logic [CNT_W-1:0] count;

  sram_ctl_timer #(.CNT_W(CNT_W), .CNT_MAX(T_CYCLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .count(count)
  );

  sram_ctl_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_CYCLE(T_CYCLE), .T_OE(T_OE), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .count(count), .restart(restart),
    .req_ready(req_ready), .read_last(read_last),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  sram_ctl_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .sample(read_last), .dq_in(mem_dq_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_wr_n,
  input logic              mem_rd_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe));

  a_r3_sel_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n == !mem_sel);

  a_r4_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ($past(mem_rd_n) && mem_rd_n));

  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  a_r8_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  a_r6_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> (!mem_sel_n && mem_sel && mem_dq_oe));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_no_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> !rsp_valid);
endmodule

bind sram_ctl sram_ctl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
  .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int TC = 4;
  localparam int TO = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe;
  logic [DW-1:0] rsp_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_bad = 0, mon_bad = 0;
  logic [DW-1:0] mem [0:255];

  always #4 clk = ~clk;

  sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .T_CYCLE(TC), .T_OE(TO)) u_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n),
    .mem_rd_n(mem_rd_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  // Memory model: drives valid data only while selected, WE high, OE low;
  // otherwise drives the complement so mistimed sampling is visible.
  always_comb begin
    if (!mem_sel_n && mem_sel && mem_wr_n && !mem_rd_n)
      mem_dq_in = mem[mem_addr[7:0]];
    else
      mem_dq_in = ~mem[mem_addr[7:0]];
  end

  always @(posedge mem_wr_n)
    if (rst_n && !mem_sel_n && mem_sel && mem_dq_oe)
      mem[mem_addr[7:0]] = mem_dq_out;

  // Pin monitor for R3/R7.
  logic prev_rd_n = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_sel_n != !mem_sel) mon_bad++;
      if (req_ready == mem_sel) mon_bad++;
      if (mem_dq_oe && !prev_oe && !prev_rd_n) mon_bad++;
    end
    prev_rd_n = mem_rd_n;
    prev_oe = mem_dq_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Issue one request, then watch the busy cycle; returns counts.
  task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int busy, output int rd_lo, output int wr_lo,
                        output int oe_hi, output bit stable_ok, output bit sv,
                        output logic [DW-1:0] sd);
    busy = 0; rd_lo = 0; wr_lo = 0; oe_hi = 0; stable_ok = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && busy < 100) begin
      busy++;
      if (!mem_rd_n) rd_lo++;
      if (!mem_wr_n) wr_lo++;
      if (mem_dq_oe) oe_hi++;
      if (mem_addr != a) stable_ok = 1'b0;
      if (wr && mem_dq_out != d) stable_ok = 1'b0;
      if (!wr && !mem_rd_n && busy <= TC - TO) stable_ok = 1'b0;
      @(negedge clk);
    end
    sv = rsp_valid; sd = rsp_data;
  endtask

  task automatic t_reset;
    chk(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe && req_ready,
        "R1 reset standby", {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe}, 5'b10110);
    chk(!rsp_valid, "R5 no strobe at reset", rsp_valid, 0);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int b, rl, wl, oh; bit st, sv; logic [DW-1:0] sd;
    run_op(1'b1, a, d, b, rl, wl, oh, st, sv, sd);
    chk(b == TC, "R2 write busy length", b, TC);
    chk(wl == TC - 1 && rl == 0, "R6 write strobe window", wl, TC - 1);
    chk(oh == TC, "R7 driver only in write", oh, TC);
    chk(st, "R8 write addr/data stable", st, 1);
    chk(!sv, "R9 no strobe after write", sv, 0);
    chk(mem[a[7:0]] == d, "R6 byte stored", mem[a[7:0]], d);
    chk(mem_sel_n && !mem_sel && !mem_dq_oe, "R1 standby after write", mem_dq_oe, 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int b, rl, wl, oh; bit st, sv; logic [DW-1:0] sd;
    run_op(1'b0, a, 8'h00, b, rl, wl, oh, st, sv, sd);
    chk(b == TC, "R2 read busy length", b, TC);
    chk(rl == TO && wl == 0 && oh == 0, "R4 read strobe window", rl, TO);
    chk(st, "R8 read addr stable / R4 late OE", st, 1);
    chk(sv && sd == exp, "R5 read data", sd, exp);
    @(negedge clk);
    chk(!rsp_valid, "R5 strobe one clock", rsp_valid, 0);
  endtask

  // Read then write same address with valid held: old byte returned, write once.
  task automatic t_b2b(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int b = 0, accepts = 0; logic [DW-1:0] old;
    logic got_v = 1'b0; logic [DW-1:0] got_d = '0;
    old = mem[a[7:0]];
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_write = 1'b1; req_wdata = d;
    while (b < 40) begin
      if (rsp_valid) begin got_v = 1'b1; got_d = rsp_data; end
      if (req_ready && req_valid) begin accepts++; end
      if (req_ready && accepts == 1) req_valid = 1'b1;
      @(negedge clk);
      if (!req_ready && req_write && mem_dq_oe && req_valid) begin
        req_valid = 1'b0;
      end
      b++;
    end
    req_valid = 1'b0;
    chk(got_v && got_d == old, "R5 read before write sees old byte", got_d, old);
    chk(mem[a[7:0]] == d, "R2 held write taken", mem[a[7:0]], d);
    chk(mon_bad == 0, "R7 turnaround before driver", mon_bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(17'h0_0011, 8'h11 ^ 8'h5A);
    t_write(17'h0_0000, 8'h00);
    t_write(17'h1_FFFF, 8'hFF);
    t_write(17'h0_AAAA, 8'h5A);
    t_read(17'h1_FFFF, 8'hFF);
    t_read(17'h0_0000, 8'h00);
    t_read(17'h0_AAAA, 8'h5A);
    t_write(17'h0_AAAA, 8'hC3);
    t_read(17'h0_AAAA, 8'hC3);
    t_b2b(17'h0_1234, 8'h96);
    t_read(17'h0_1234, 8'h96);
    chk(mon_bad == 0, "R3 select pair and busy match", mon_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule